// File: doc/BRIEF.md
# Dual-Pattern Serial Sequence Recogniser

This block watches a serial bit stream, one bit per accepted clock cycle, and flags the arrival of either of two four-bit patterns: `1001` and `1111`. The flag is combinational from the present state and the current bit (Mealy behaviour). It rises in the same cycle that the last bit of a pattern is presented, so no extra latency is added. Occurrences may overlap. The trailing bits of one hit are reused as the start of the next.

A single merged state graph of six states tracks only the suffix of the stream that can still lead to a hit. No state of that graph is equivalent to another, so the set cannot be reduced. A qualifier input marks which cycles carry a real bit. Unqualified cycles are skipped entirely, so the bits on either side of a gap join into one stream. A synchronous active-low reset discards all history.

Top module: `seq_pair_detector`

## Requirements
- R1: `match` is 1 in a qualified cycle when the last three accepted bits, followed by the current `bit_in`, read `1001` (oldest first).
- R2: `match` is 1 in a qualified cycle when the last three accepted bits, followed by the current `bit_in`, read `1111`.
- R3: In every other cycle `match` is 0. This includes every cycle in which fewer than three bits have been accepted since reset.
- R4: Overlapping occurrences are reported. A run of n ones (n ≥ 4) gives n−3 consecutive hits, and the final 1 of `1001` can begin a new `1001` or `1111`.
- R5: After reset, the stream 010111100110011111 (leftmost first, all bits qualified) produces `match` = 000000100100010011.
- R6: The state register only ever holds one of six legal codes (0 to 5). Each code stands for a distinct suffix class: none, 1, 10, 100, 11, 111.
- R7: While `rst_n` is low at a rising edge, the history is cleared and `match` is 0 throughout the reset cycle. Counting of the four bits starts again afterwards.
- R8: When `bit_vld` is 0, `match` is 0 and the state is unchanged at the next edge. The bits on either side of the gap are treated as adjacent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_vld | input | 1 | High when `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Serial stream bit |
| match | output | 1 | High when this bit completes 1001 or 1111 |

## Verification
Some cycles carry two jobs at once: the same bit completes one occurrence and also opens the next. This happens in runs such as 1111111, 1001001 and 1001111. Directed segments build these runs, some with unqualified gaps placed inside them. The bench judges every cycle against a behavioural model that keeps the last three accepted bits in a queue. The given example stream is also compared bit by bit against its literal expected output.

// File: rtl/sqd_pkg.sv
// Package: shared state type for the dual-pattern recogniser.
// Assumes: six suffix classes suffice for patterns 1001 and 1111.
package sqd_pkg;
    localparam int NUM_STATES = 6;
    localparam int STATE_W    = $clog2(NUM_STATES);

    // Suffix classes: longest stream tail that is a prefix of a pattern.
    typedef enum logic [STATE_W-1:0] {
        ST_NONE = 3'd0,
        ST_1    = 3'd1,
        ST_10   = 3'd2,
        ST_100  = 3'd3,
        ST_11   = 3'd4,
        ST_111  = 3'd5
    } sqd_state_t;
endpackage

// File: rtl/sqd_next_state.sv
// Module: next-state function of the merged suffix graph.
// Assumes: caller decides whether the result is loaded (qualifier).
// Unknown codes fall back to ST_NONE.
module sqd_next_state
    import sqd_pkg::*;
(
    input  sqd_state_t cur,
    input  logic       bit_in,
    output sqd_state_t nxt
);
    // Transition table of the six-state graph.
    always_comb begin
        unique case (cur)
            ST_NONE: nxt = bit_in ? ST_1   : ST_NONE;
            ST_1:    nxt = bit_in ? ST_11  : ST_10;
            ST_10:   nxt = bit_in ? ST_1   : ST_100;
            ST_100:  nxt = bit_in ? ST_1   : ST_NONE;
            ST_11:   nxt = bit_in ? ST_111 : ST_10;
            ST_111:  nxt = bit_in ? ST_111 : ST_10;
            default: nxt = ST_NONE;
        endcase
    end
endmodule

// File: rtl/sqd_match_decode.sv
// Module: Mealy output decode; flags a completed pattern.
// Assumes: bit_vld and rst_n gate the flag in the same cycle.
module sqd_match_decode
    import sqd_pkg::*;
(
    input  sqd_state_t cur,
    input  logic       bit_in,
    input  logic       bit_vld,
    input  logic       rst_n,
    output logic       match
);
    // Hit when a final 1 lands on the 100 or 111 suffix.
    always_comb begin
        match = 1'b0;
        if (rst_n && bit_vld && bit_in)
            match = (cur == ST_100) || (cur == ST_111);
    end
endmodule

// File: rtl/sqd_state_reg.sv
// Module: state register with synchronous active-low reset.
// Assumes: the state holds in any cycle without a qualified bit.
module sqd_state_reg
    import sqd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  sqd_state_t nxt,
    output sqd_state_t cur
);
    // Clear on reset, advance only on a qualified bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= ST_NONE;
        else if (load)
            cur <= nxt;
    end
endmodule

// File: rtl/seq_pair_detector.sv
// Module: top of the dual-pattern (1001 / 1111) overlapping recogniser.
// Assumes: one serial bit per qualified cycle; output is combinational.
module seq_pair_detector
    import sqd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    output logic match
);
    sqd_state_t state_q;
    sqd_state_t state_d;

    sqd_next_state u_next (
        .cur    (state_q),
        .bit_in (bit_in),
        .nxt    (state_d)
    );

    sqd_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bit_vld),
        .nxt   (state_d),
        .cur   (state_q)
    );

    sqd_match_decode u_dec (
        .cur     (state_q),
        .bit_in  (bit_in),
        .bit_vld (bit_vld),
        .rst_n   (rst_n),
        .match   (match)
    );
endmodule

// File: rtl/sqd_checker.sv
// Module: property checker bound to seq_pair_detector.
// Keeps its own three-bit history of accepted bits and a saturating count.
module sqd_checker
    import sqd_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                bit_vld,
    input logic                bit_in,
    input logic                match,
    input logic [STATE_W-1:0]  state
);
    logic [2:0] hist;
    logic [1:0] seen;

    // Track the accepted-bit history independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= 3'b000;
            seen <= 2'd0;
        end else if (bit_vld) begin
            hist <= {hist[1:0], bit_in};
            if (seen != 2'd3) seen <= seen + 2'd1;
        end
    end

    logic full;
    logic [3:0] win;
    assign full = (seen == 2'd3);
    assign win  = {hist, bit_in};

    AST_HIT_1001: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && full && win == 4'b1001) |-> match);   // R1
    AST_HIT_1111: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && full && win == 4'b1111) |-> match);   // R2
    AST_NO_FALSE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (bit_vld && full && (win == 4'b1001 || win == 4'b1111))); // R3
    AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        state < 3'(NUM_STATES));                          // R6
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> state == 3'(ST_NONE));                 // R7
    AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |-> !match);                             // R8
    AST_HOLD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld && $past(rst_n)) |=> $stable(state));   // R8
endmodule

bind seq_pair_detector sqd_checker chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .match   (match),
    .state   (state_q)
);

// File: tb/seq_pair_detector_tb_top.sv
// Bench: drives directed and random streams and compares match every
// cycle against a behavioural queue model of the last three accepted bits.
module seq_pair_detector_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b0;
    logic match;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit q[$];

    seq_pair_detector dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .match   (match)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // One cycle: drive, compare to model (and optional literal), update model.
    task automatic step(input logic r, input logic v, input logic b,
                        input string tag, input int lit = -1);
        logic exp;
        logic [3:0] win;
        @(negedge clk);
        rst_n = r; bit_vld = v; bit_in = b;
        #1;
        exp = 1'b0;
        if (r && v && q.size() == 3) begin
            win = {q[0], q[1], q[2], b};
            exp = (win == 4'b1001) || (win == 4'b1111);
        end
        n_cmp++;
        if (match !== exp) begin
            n_bad++;
            $display("FAIL %s: match=%b expected=%b", tag, match, exp);
        end
        if (lit >= 0) begin
            n_cmp++;
            if (match !== lit[0]) begin
                n_bad++;
                $display("FAIL %s literal: match=%b expected=%0d", tag, match, lit);
            end
        end
        @(posedge clk);
        if (!r) q.delete();
        else if (v) begin
            q.push_back(b);
            if (q.size() > 3) void'(q.pop_front());
        end
    endtask

    task automatic feed(input logic [31:0] bits, input int len, input string tag);
        for (int i = len - 1; i >= 0; i--) step(1'b1, 1'b1, bits[i], tag);
    endtask

    task automatic do_reset(input string tag);
        step(1'b0, 1'b1, 1'b1, tag);
        step(1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        logic [17:0] wv;
        logic [17:0] zv;
        wv = 18'b010111100110011111;
        zv = 18'b000000100100010011;

        // R7: reset state, match low while reset is held with a 1 present
        do_reset("R7 reset");
        // R5: the given example stream with literal output
        for (int i = 17; i >= 0; i--)
            step(1'b1, 1'b1, wv[i], "R5 example", int'(zv[i]));
        // R1: single 1001 after reset
        do_reset("R1");
        feed(32'b1001, 4, "R1 1001");
        // R2 and R4: run of seven ones hits on bits 4..7
        do_reset("R2");
        feed(32'b1111111, 7, "R2/R4 ones run");
        // R4: 1001001 and 1001111 overlaps
        do_reset("R4");
        feed(32'b1001001, 7, "R4 1001001");
        do_reset("R4");
        feed(32'b1001111, 7, "R4 1001111");
        // R3: near misses and short streams
        do_reset("R3");
        feed(32'b111, 3, "R3 short");
        feed(32'b0101101100, 10, "R3 near miss");
        // R8: gaps inside a pattern join the bits
        do_reset("R8");
        step(1'b1, 1'b1, 1'b1, "R8 gap");
        step(1'b1, 1'b0, 1'b1, "R8 gap");
        step(1'b1, 1'b1, 1'b0, "R8 gap");
        step(1'b1, 1'b0, 1'b0, "R8 gap");
        step(1'b1, 1'b0, 1'b1, "R8 gap");
        step(1'b1, 1'b1, 1'b0, "R8 gap");
        step(1'b1, 1'b1, 1'b1, "R8 gap");
        // R7: reset in the middle of a pattern discards history
        feed(32'b100, 3, "R7 pre");
        step(1'b0, 1'b1, 1'b1, "R7 mid reset");
        step(1'b1, 1'b1, 1'b1, "R7 after reset");
        feed(32'b111, 3, "R7 after reset");
        // R3/R4/R6/R8: random streams, ones-biased, with random gaps
        for (int s = 0; s < 3; s++) begin
            do_reset("R3 random");
            for (int i = 0; i < 2000; i++)
                step(($urandom % 300) != 0, ($urandom % 5) != 0,
                     (s == 0) ? 1'($urandom) : (($urandom % 4) != 0),
                     "R3 random");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule